// File: doc/BRIEF.md
# Instruction Fetch Unit with Next-Address Selection

This block holds the program counter of a small processor whose instruction words are 9 bits wide. It also holds the instruction store that those words are read from. Every cycle it chooses the next program counter from four sources, in a fixed priority order. The store is read combinationally, so the instruction for the current counter value is available in the same cycle as the counter itself. The block knows nothing about opcodes. A decoder elsewhere tells it whether the current instruction is a branch, the condition logic tells it whether the branch is taken, and the datapath supplies the destination.

The surrounding system uses a reset and a start request to sequence programs. Reset returns the counter to address zero, where the first program lives. While start is high, the counter is loaded from the start-address input and parked there. When start drops, execution begins at that address. A build parameter chooses how the destination input is read. In absolute mode it is the new counter value. In relative mode it is a two's-complement distance that is added to the current counter. The store holds three short program segments separated by NO-OP words.

Top module: `fetch_unit`

## Requirements
- R1: Reset is asynchronous and active high. While it is high the counter reads 0, and it overrides every other input.
- R2: When start is low and branch is low, the counter advances by exactly one on each clock edge, whatever the value of taken.
- R3: In absolute mode (REL_TARGET=0), when start is low and branch and taken are both high, the counter becomes the value of target on the next edge.
- R4: When start is low, branch is high and taken is low, the counter advances by one, exactly as in R2.
- R5: In relative mode (REL_TARGET=1), a taken branch with start low makes the counter equal to the current counter plus target, where target is read as a signed 12-bit two's-complement number. The distance is measured from the branch's own address.
- R6: While start is high, each edge loads start_addr into the counter, and the counter stays there for as long as start stays high. Start takes priority over a taken branch.
- R7: Counter arithmetic wraps modulo 4096. Incrementing from 0xFFF gives 0x000, and relative sums wrap the same way.
- R8: The instruction output is a combinational function of the current counter. For each segment base b in {0, 16, 32}, every address a in the range b to b+11 holds {3'b101, a[5:0]}. Every other address, including all addresses at or above ROM_DEPTH (64), holds the NO-OP word 9'h000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous active-high reset; forces the counter to 0 |
| start | input | 1 | Load start_addr and hold there while high |
| start_addr | input | 12 | Entry address of the program to run |
| branch | input | 1 | Current instruction is a branch |
| taken | input | 1 | Branch resolved as taken; ignored when branch is low |
| target | input | 12 | Branch destination: an absolute address or a signed distance, depending on REL_TARGET |
| pc | output | 12 | Current program counter |
| insn | output | 9 | Instruction word stored at pc |

## Verification
The hardest condition to reach from the ports is the top of the counter range. To get there, an increment would have to run for thousands of cycles, and the addresses above the populated store would have to be read on the way. The stimulus avoids the long run by using start itself. It parks the counter at 0xFFF through start_addr, checks that a NO-OP is read there, and then releases start to watch the counter wrap to zero. Relative wrap is reached the same way, with a negative distance taken from address 2. A second instance built in relative mode receives the same inputs, so that both meanings of target are checked against the same stimulus.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int INSN_BITS = 9;
    localparam logic [INSN_BITS-1:0] NOP_WORD = '0;
    localparam logic [2:0] SEG_OPCODE = 3'b101;

    typedef enum logic [1:0] {
        SEL_INCR   = 2'd0,
        SEL_BRANCH = 2'd1,
        SEL_START  = 2'd2
    } next_sel_e;

endpackage

// File: rtl/fetch_dest.sv
module fetch_dest #(
    parameter int PC_W       = 12,
    parameter bit REL_TARGET = 1'b0
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic [PC_W-1:0] target_i,
    output logic [PC_W-1:0] dest_o
);

    generate
        if (REL_TARGET) begin : g_relative
            // signed distance from the branch's own address; wraps naturally
            always_comb begin
                dest_o = pc_i + target_i;
            end
        end else begin : g_absolute
            always_comb begin
                dest_o = target_i;
            end
        end
    endgenerate

endmodule

// File: rtl/fetch_rom.sv
module fetch_rom
    import fetch_pkg::*;
#(
    parameter int PC_W       = 12,
    parameter int INSN_W     = INSN_BITS,
    parameter int ROM_DEPTH  = 64,
    parameter int SEG_COUNT  = 3,
    parameter int SEG_STRIDE = 16,
    parameter int SEG_LEN    = 12
) (
    input  logic [PC_W-1:0]   addr_i,
    output logic [INSN_W-1:0] word_o
);

    localparam int IDX_W = (ROM_DEPTH > 1) ? $clog2(ROM_DEPTH) : 1;
    localparam int LOW_W = INSN_W - 3;

    logic [INSN_W-1:0] words [ROM_DEPTH];

    function automatic logic [INSN_W-1:0] word_at(input int a);
        logic [31:0] av;
        av = 32'(a);
        word_at = INSN_W'(NOP_WORD);
        for (int s = 0; s < SEG_COUNT; s++) begin
            if (a >= s * SEG_STRIDE && a < s * SEG_STRIDE + SEG_LEN) begin
                word_at = {SEG_OPCODE, av[LOW_W-1:0]};
            end
        end
    endfunction

    generate
        for (genvar i = 0; i < ROM_DEPTH; i++) begin : g_word
            assign words[i] = word_at(i);
        end
    endgenerate

    always_comb begin
        if (32'(addr_i) < ROM_DEPTH) begin
            word_o = words[addr_i[IDX_W-1:0]];
        end else begin
            word_o = INSN_W'(NOP_WORD);
        end
    end

endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
    import fetch_pkg::*;
#(
    parameter int PC_W       = 12,
    parameter int INSN_W     = INSN_BITS,
    parameter int ROM_DEPTH  = 64,
    parameter bit REL_TARGET = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PC_W-1:0]   start_addr,
    input  logic              branch,
    input  logic              taken,
    input  logic [PC_W-1:0]   target,
    output logic [PC_W-1:0]   pc,
    output logic [INSN_W-1:0] insn
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } state_t;

    state_t    st_d, st_q;
    next_sel_e sel_d;
    logic [PC_W-1:0] dest_d;

    fetch_dest #(
        .PC_W       (PC_W),
        .REL_TARGET (REL_TARGET)
    ) u_dest (
        .pc_i     (st_q.pc),
        .target_i (target),
        .dest_o   (dest_d)
    );

    fetch_rom #(
        .PC_W      (PC_W),
        .INSN_W    (INSN_W),
        .ROM_DEPTH (ROM_DEPTH)
    ) u_rom (
        .addr_i (st_q.pc),
        .word_o (insn)
    );

    always_comb begin
        if (start) begin
            sel_d = SEL_START;
        end else if (branch && taken) begin
            sel_d = SEL_BRANCH;
        end else begin
            sel_d = SEL_INCR;
        end

        st_d = st_q;
        unique case (sel_d)
            SEL_START:  st_d.pc = start_addr;
            SEL_BRANCH: st_d.pc = dest_d;
            default:    st_d.pc = st_q.pc + PC_W'(1);
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc = st_q.pc;

endmodule

// File: rtl/fetch_unit_chk.sv
module fetch_unit_chk #(
    parameter int PC_W       = 12,
    parameter int INSN_W     = 9,
    parameter int ROM_DEPTH  = 64,
    parameter bit REL_TARGET = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [PC_W-1:0]   start_addr,
    input logic              branch,
    input logic              taken,
    input logic [PC_W-1:0]   target,
    input logic [PC_W-1:0]   pc,
    input logic [INSN_W-1:0] insn
);

    // R1: the first edge after reset is released still sees address zero
    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> pc == '0);

    // R2, R4, R7: no start and no taken branch means a step of one, modulo 4096
    assert_step_one_R2: assert property (@(posedge clk) disable iff (rst)
        (!start && !(branch && taken)) |=> pc == $past(pc) + PC_W'(1));

    // R6: start loads the requested entry point
    assert_start_load_R6: assert property (@(posedge clk) disable iff (rst)
        start |=> pc == $past(start_addr));

    // R6: the counter stays parked while start is held
    assert_start_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (start && $past(start) && $stable(start_addr)) |=> $stable(pc));

    generate
        if (REL_TARGET) begin : g_rel
            // R5: relative destination
            assert_rel_branch_R5: assert property (@(posedge clk) disable iff (rst)
                (!start && branch && taken) |=> pc == $past(pc) + $past(target));
        end else begin : g_abs
            // R3: absolute destination
            assert_abs_branch_R3: assert property (@(posedge clk) disable iff (rst)
                (!start && branch && taken) |=> pc == $past(target));
        end
    endgenerate

    // R8: addresses past the populated store read as NO-OP
    assert_gap_nop_R8: assert property (@(posedge clk) disable iff (rst)
        (32'(pc) >= ROM_DEPTH) |-> insn == '0);

endmodule

bind fetch_unit fetch_unit_chk #(
    .PC_W       (PC_W),
    .INSN_W     (INSN_W),
    .ROM_DEPTH  (ROM_DEPTH),
    .REL_TARGET (REL_TARGET)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_addr (start_addr),
    .branch     (branch),
    .taken      (taken),
    .target     (target),
    .pc         (pc),
    .insn       (insn)
);

// File: tb/tb_fetch_unit.sv
`timescale 1ns/1ps
module tb_fetch_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] start_addr = '0;
    logic        branch = 1'b0;
    logic        taken = 1'b0;
    logic [11:0] target = '0;
    logic [11:0] pc_a, pc_r;
    logic [8:0]  insn_a, insn_r;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fetch_unit #(.REL_TARGET(1'b0)) dut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .branch(branch), .taken(taken), .target(target),
        .pc(pc_a), .insn(insn_a)
    );

    fetch_unit #(.REL_TARGET(1'b1)) dut_rel (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .branch(branch), .taken(taken), .target(target),
        .pc(pc_r), .insn(insn_r)
    );

    function automatic logic [8:0] exp_insn(input int a);
        logic [31:0] av = 32'(a);
        for (int s = 0; s < 3; s++) begin
            if (a >= 16 * s && a < 16 * s + 12) return {3'b101, av[5:0]};
        end
        return 9'h000;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        chk("R1 pc in reset", 16'(pc_a), 16'h000);
        chk("R8 insn at 0", 16'(insn_a), 16'(exp_insn(0)));
        rst = 1'b0;
    endtask

    task automatic t_increment();
        logic [11:0] e;
        branch = 1'b0;
        taken  = 1'b1;
        target = 12'h3A0;
        e = pc_a;
        for (int i = 0; i < 5; i++) begin
            step();
            e = e + 12'd1;
            chk("R2 increment, taken ignored", 16'(pc_a), 16'(e));
        end
        taken = 1'b0;
    endtask

    task automatic t_abs_jump();
        branch = 1'b1;
        taken  = 1'b1;
        target = 12'h020;
        step();
        chk("R3 absolute jump", 16'(pc_a), 16'h020);
        chk("R8 insn after jump", 16'(insn_a), 16'(exp_insn(32)));
        branch = 1'b0;
        taken  = 1'b0;
    endtask

    task automatic t_not_taken();
        logic [11:0] ea, er;
        ea = pc_a + 12'd1;
        er = pc_r + 12'd1;
        branch = 1'b1;
        taken  = 1'b0;
        target = 12'h007;
        step();
        chk("R4 not taken abs", 16'(pc_a), 16'(ea));
        chk("R4 not taken rel", 16'(pc_r), 16'(er));
        branch = 1'b0;
    endtask

    task automatic t_start_hold();
        start = 1'b1;
        start_addr = 12'h010;
        branch = 1'b1;
        taken  = 1'b1;
        target = 12'h300;
        step();
        chk("R6 start load abs", 16'(pc_a), 16'h010);
        chk("R6 start load rel", 16'(pc_r), 16'h010);
        repeat (3) step();
        chk("R6 start hold", 16'(pc_a), 16'h010);
        chk("R6 start hold rel", 16'(pc_r), 16'h010);
        start  = 1'b0;
        branch = 1'b0;
        taken  = 1'b0;
        step();
        chk("R6 run after start", 16'(pc_a), 16'h011);
    endtask

    task automatic t_wrap();
        start = 1'b1;
        start_addr = 12'hFFF;
        step();
        chk("R6 park at top", 16'(pc_a), 16'hFFF);
        chk("R8 nop above store", 16'(insn_a), 16'h000);
        start = 1'b0;
        step();
        chk("R7 wrap to zero", 16'(pc_a), 16'h000);
        chk("R8 insn after wrap", 16'(insn_a), 16'(exp_insn(0)));
    endtask

    task automatic t_relative();
        start = 1'b1;
        start_addr = 12'h020;
        step();
        start  = 1'b0;
        branch = 1'b1;
        taken  = 1'b1;
        target = 12'h005;
        step();
        chk("R5 forward distance", 16'(pc_r), 16'h025);
        chk("R3 abs same stimulus", 16'(pc_a), 16'h005);
        target = 12'hFFD;
        step();
        chk("R5 backward distance", 16'(pc_r), 16'h022);
        chk("R3 abs high target", 16'(pc_a), 16'hFFD);
        branch = 1'b0;
        taken  = 1'b0;
        start = 1'b1;
        start_addr = 12'h002;
        step();
        start  = 1'b0;
        branch = 1'b1;
        taken  = 1'b1;
        target = 12'hFFC;
        step();
        chk("R7 relative wrap", 16'(pc_r), 16'hFFE);
        branch = 1'b0;
        taken  = 1'b0;
        step();
        chk("R2 rel increment", 16'(pc_r), 16'hFFF);
    endtask

    task automatic t_async_reset();
        @(negedge clk);
        rst = 1'b1;
        #0.5;
        chk("R1 async clear abs", 16'(pc_a), 16'h000);
        chk("R1 async clear rel", 16'(pc_r), 16'h000);
        start = 1'b1;
        start_addr = 12'h0AB;
        step();
        chk("R1 reset beats start", 16'(pc_a), 16'h000);
        start = 1'b0;
        rst = 1'b0;
    endtask

    task automatic t_rom_scan();
        chk("R8 scan addr 0", 16'(insn_a), 16'(exp_insn(0)));
        for (int a = 1; a < 70; a++) begin
            step();
            chk("R2 scan pc", 16'(pc_a), 16'(a));
            chk("R8 scan insn", 16'(insn_a), 16'(exp_insn(a)));
        end
    endtask

    initial begin
        t_reset();
        t_increment();
        t_abs_jump();
        t_not_taken();
        t_start_hold();
        t_wrap();
        t_relative();
        t_async_reset();
        t_rom_scan();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule